// File: doc/BRIEF.md
# Abstract register-access command engine

This block turns one abstract command word, handed over by a debug module on a single-cycle launch pulse, into a two-instruction stub that a halted hart can run. It checks the command against the current error state, the busy flag and the halted state of the selected hart, and it does so in a fixed priority order. If every check passes, it writes two 32-bit instruction words into the hart's code buffer and asks for busy to be set. If a check fails, it reports a new error code instead and generates nothing.

The first instruction moves a general-purpose register to or from the data area, using x0 as the base register and the data-area offset as the immediate. When no transfer is requested, it is a harmless store of x0. The second instruction is either a jump to the program buffer or an ebreak. The encodings are standard RV32/RV64 words. All results are registered and appear exactly one clock after the launch.

Top module: `abscmd_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `code_we`, `err_we` and `busy_set` are 0, and `word0`, `word1` and `err_out` are 0.
- R2: A launch while `err_in` is non-zero is ignored. In the next cycle `code_we`, `err_we` and `busy_set` are 0, and `word0` and `word1` keep their previous values.
- R3: A launch with `err_in` = 0 and `busy_in` = 1 gives `err_we` = 1 with `err_out` = 1 (busy) in the next cycle, and `code_we` = 0.
- R4: If R2 and R3 do not apply and `cmd[31:24]` is not 0, the result is `err_out` = 2 (not supported).
- R5: If none of the above applies and `cmd[15:0]` lies outside 0x1000..0x101F, the result is `err_out` = 2. Otherwise the target register number is `cmd[15:0]` minus 0x1000.
- R6: If none of the above applies and `hart_halted` = 0, the result is `err_out` = 4 (halt/resume).
- R7: If none of the above applies, transfer (`cmd[17]`) = 1 and size (`cmd[22:20]`) is neither 2 nor 3, the result is `err_out` = 2. When transfer = 0, the size field is not checked.
- R8: With transfer = 1 and write (`cmd[16]`) = 1, `word0` is a load into the target register: `{imm12, rs1=0, funct3, rd, 7'b0000011}`. funct3 is 3'b010 for size 2 and 3'b011 for size 3, and imm12 is the data-area offset (default 0x380).
- R9: With transfer = 1 and write = 0, `word0` is a store of the target register: `{imm[11:5], rs2=rd, rs1=0, funct3, imm[4:0], 7'b0100011}`, with the same funct3 and immediate as R8.
- R10: With transfer = 0, `word0` is a word store of x0 to the data area (rs2 = 0, funct3 = 3'b010).
- R11: With postexec (`cmd[18]`) = 1, `word1` is a JAL with rd = x0 and offset equal to the program-buffer address minus (code-buffer address + 4); with the defaults (0x340 and 0x300) the offset is 0x3C. With postexec = 0, `word1` is 0x00100073.
- R12: A command that passes every check gives `code_we` = 1 and `busy_set` = 1 for exactly one cycle, the cycle after the launch, with `err_we` = 0.
- R13: In a cycle that follows a cycle with no launch, `code_we`, `err_we` and `busy_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | One-cycle pulse that presents a command |
| cmd | input | 32 | Abstract command word |
| err_in | input | 3 | Current error code (0 = none) |
| busy_in | input | 1 | A command is already in progress |
| hart_halted | input | 1 | The selected hart is halted |
| word0 | output | 32 | First generated instruction |
| word1 | output | 32 | Second generated instruction |
| code_we | output | 1 | Write strobe for word0/word1 into the code buffer |
| err_out | output | 3 | New error code |
| err_we | output | 1 | Strobe to update the error code |
| busy_set | output | 1 | Request to set busy |

## Verification
Several error conditions can be true on the same launch: an existing error together with busy, an unsupported type with an out-of-range register, or a running hart together with a bad size. Only the highest-priority condition may take effect. The sweep drives every combination of these conditions together on one launch and computes the expected winner from the priority order R2 through R7. Each response is judged on the strobes and on the error code in the cycle after the launch, and a generated stub must never appear alongside an error strobe.

// File: rtl/abscmd_engine.sv
module abscmd_engine #(
  parameter logic [31:0] CODE_ADDR = 32'h0000_0300,
  parameter logic [31:0] PROG_ADDR = 32'h0000_0340,
  parameter logic [11:0] DATA_OFS  = 12'h380,
  parameter logic [15:0] REG_BASE  = 16'h1000,
  parameter int          REG_COUNT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [31:0] cmd,
  input  logic [2:0]  err_in,
  input  logic        busy_in,
  input  logic        hart_halted,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        code_we,
  output logic [2:0]  err_out,
  output logic        err_we,
  output logic        busy_set
);
  localparam logic [2:0]  E_BUSY   = 3'd1;
  localparam logic [2:0]  E_NOTSUP = 3'd2;
  localparam logic [2:0]  E_HALT   = 3'd4;
  localparam logic [31:0] EBREAK   = 32'h0010_0073;
  localparam logic [31:0] JOFF     = PROG_ADDR - (CODE_ADDR + 32'd4);
  localparam logic [31:0] JAL_WORD = {JOFF[20], JOFF[10:1], JOFF[11], JOFF[19:12], 5'd0, 7'b1101111};
  localparam logic [31:0] REG_END  = {16'd0, REG_BASE} + REG_COUNT;

  wire [7:0]  ctype = cmd[31:24];
  wire [2:0]  size  = cmd[22:20];
  wire        postx = cmd[18];
  wire        xfer  = cmd[17];
  wire        wr    = cmd[16];
  wire [15:0] regno = cmd[15:0];
  wire [15:0] ridx  = regno - REG_BASE;
  wire [4:0]  rd    = ridx[4:0];

  wire in_range = (regno >= REG_BASE) && ({16'd0, regno} < REG_END);
  wire size_ok  = !xfer || (size == 3'd2) || (size == 3'd3);
  wire [2:0] f3 = xfer ? {2'b01, size[0]} : 3'b010;
  wire [4:0] rs2 = xfer ? rd : 5'd0;

  wire [31:0] ld_word = {DATA_OFS, 5'd0, f3, rd, 7'b0000011};
  wire [31:0] st_word = {DATA_OFS[11:5], rs2, 5'd0, f3, DATA_OFS[4:0], 7'b0100011};
  wire [31:0] w0 = (xfer && wr) ? ld_word : st_word;
  wire [31:0] w1 = postx ? JAL_WORD : EBREAK;

  logic       do_err, do_gen;
  logic [2:0] nerr;

  always_comb begin
    do_err = 1'b0;
    do_gen = 1'b0;
    nerr   = 3'd0;
    if (launch && err_in == 3'd0) begin
      do_err = 1'b1;
      if (busy_in)              nerr = E_BUSY;
      else if (ctype != 8'd0)   nerr = E_NOTSUP;
      else if (!in_range)       nerr = E_NOTSUP;
      else if (!hart_halted)    nerr = E_HALT;
      else if (!size_ok)        nerr = E_NOTSUP;
      else begin
        do_err = 1'b0;
        do_gen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word0    <= '0;
      word1    <= '0;
      code_we  <= 1'b0;
      err_out  <= '0;
      err_we   <= 1'b0;
      busy_set <= 1'b0;
    end else begin
      code_we  <= do_gen;
      busy_set <= do_gen;
      err_we   <= do_err;
      if (do_err) err_out <= nerr;
      if (do_gen) begin
        word0 <= w0;
        word1 <= w1;
      end
    end
  end
endmodule

module abscmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic [31:0] cmd,
  input logic [2:0]  err_in,
  input logic        busy_in,
  input logic        hart_halted,
  input logic [31:0] word1,
  input logic        code_we,
  input logic [2:0]  err_out,
  input logic        err_we,
  input logic        busy_set
);
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && err_in != 3'd0) |=> (!err_we && !code_we && !busy_set));

  assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && err_in == 3'd0 && busy_in) |=> (err_we && err_out == 3'd1 && !code_we));

  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && err_in == 3'd0 && !busy_in && cmd[31:24] == 8'd0 &&
     cmd[15:0] >= 16'h1000 && cmd[15:0] < 16'h1020 && !hart_halted)
    |=> (err_we && err_out == 3'd4));

  assert_ebreak_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !cmd[18]) |=> (!code_we || word1 == 32'h0010_0073));

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    code_we |-> (busy_set && !err_we));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (!code_we && !err_we && !busy_set));
endmodule

bind abscmd_engine abscmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd), .err_in(err_in),
  .busy_in(busy_in), .hart_halted(hart_halted), .word1(word1),
  .code_we(code_we), .err_out(err_out), .err_we(err_we), .busy_set(busy_set)
);

// File: tb/abscmd_engine_bench.sv
`timescale 1ns/1ps
module abscmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch = 1'b0;
  logic [31:0] cmd = '0;
  logic [2:0]  err_in = '0;
  logic        busy_in = 1'b0;
  logic        hart_halted = 1'b0;
  logic [31:0] word0, word1;
  logic        code_we, err_we, busy_set;
  logic [2:0]  err_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] last0 = '0, last1 = '0;

  always #4 clk = ~clk;

  abscmd_engine u_abscmd_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd), .err_in(err_in),
    .busy_in(busy_in), .hart_halted(hart_halted), .word0(word0), .word1(word1),
    .code_we(code_we), .err_out(err_out), .err_we(err_we), .busy_set(busy_set)
  );

  function automatic logic [31:0] jal_exp();
    int off;
    off = 32'h340 - 32'h300 - 4;
    return (((off >> 20) & 1) << 31) | (((off >> 1) & 32'h3ff) << 21) |
           (((off >> 11) & 1) << 20) | (((off >> 12) & 32'hff) << 12) | 32'h6f;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] e, input logic b, input logic h, input logic [31:0] c);
    logic gen, ew;
    logic [2:0] xe;
    logic [31:0] x0, x1;
    int rn, sz, imm;
    string tag;
    @(negedge clk);
    check("R13 idle strobes", {61'd0, code_we, err_we, busy_set}, 64'd0);
    err_in = e; busy_in = b; hart_halted = h; cmd = c; launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    rn = c[15:0]; sz = c[22:20]; imm = 32'h380;
    gen = 0; ew = 1; xe = 0;
    if (e != 0) begin ew = 0; tag = "R2"; end
    else if (b) begin xe = 1; tag = "R3"; end
    else if (c[31:24] != 0) begin xe = 2; tag = "R4"; end
    else if (rn < 4096 || rn > 4096 + 31) begin xe = 2; tag = "R5"; end
    else if (!h) begin xe = 4; tag = "R6"; end
    else if (c[17] && sz != 2 && sz != 3) begin xe = 2; tag = "R7"; end
    else begin
      ew = 0; gen = 1; rn = rn - 4096;
      if (!c[17]) begin
        x0 = ((imm / 32) << 25) | (2 << 12) | ((imm % 32) << 7) | 32'h23; tag = "R10/R12";
      end else if (c[16]) begin
        x0 = (imm << 20) | (sz << 12) | (rn << 7) | 32'h03; tag = "R8/R12";
      end else begin
        x0 = ((imm / 32) << 25) | (rn << 20) | (sz << 12) | ((imm % 32) << 7) | 32'h23; tag = "R9/R12";
      end
      x1 = c[18] ? jal_exp() : 32'h0010_0073;
      last0 = x0; last1 = x1;
    end
    if (c[18]) tag = {tag, "/R11"};
    check(tag, {59'd0, gen, gen, ew, ew ? xe : 3'd0},
               {59'd0, code_we, busy_set, err_we, err_we ? err_out : 3'd0});
    check({tag, " words"}, {word0, word1}, {last0, last1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {word0, 23'd0, code_we, err_we, busy_set, err_out, 3'd0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {word1, 23'd0, code_we, err_we, busy_set, err_out, 3'd0}, 64'd0);
    foreach (int_set_e[i]) ;
    for (int ei = 0; ei < 3; ei++)
      for (int bi = 0; bi < 2; bi++)
        for (int hi = 0; hi < 2; hi++)
          for (int ti = 0; ti < 3; ti++)
            for (int ri = 0; ri < 6; ri++)
              for (int si = 0; si < 8; si++)
                for (int fi = 0; fi < 8; fi++) begin
                  logic [2:0] e;
                  logic [7:0] ty;
                  logic [15:0] rg;
                  e  = (ei == 0) ? 3'd0 : (ei == 1) ? 3'd1 : 3'd4;
                  ty = (ti == 0) ? 8'd0 : (ti == 1) ? 8'd1 : 8'hff;
                  case (ri)
                    0: rg = 16'h0fff;
                    1: rg = 16'h1000;
                    2: rg = 16'h1005;
                    3: rg = 16'h101f;
                    4: rg = 16'h1020;
                    default: rg = 16'h0000;
                  endcase
                  run(e, bi[0], hi[0], {ty, 1'b0, si[2:0], 1'b0, fi[2:0], rg});
                end
    @(negedge clk);
    check("R13 final idle", {61'd0, code_we, err_we, busy_set}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic int_set_e [1];

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule